// File: doc/BRIEF.md
# D-PHY PLL Divider Selector

This block turns a requested high-speed lane rate, in kHz, into a complete set of PLL divider fields for a D-PHY transmitter. It uses a fixed 19.2 MHz configuration clock, which has an integer period of 52083 ps. First it finds which of ten frequency bands the request falls in. That band fixes the VCO range bit and the output divider. From there the block derives the integer part and the tenths digit of the feedback ratio. These two values choose the feedback multiplier and divider, and from them the predivider and split fields. Finally the block recomputes the rate that this setting actually produces.

If the recomputed rate is below the request, the request is raised by 10 kHz and the whole evaluation runs again. This repeats until the achieved rate covers the request, the request leaves the supported range, or an iteration cap is reached. When the search succeeds, the block also derives two clock-lane timing counts from the achieved rate. It reports three fixed lane constants alongside them.

A controller starts the block with a single-cycle `start` pulse and waits for `done`. After `done`, the outputs stay valid until the next accepted start.

Top module: `dphy_pll_search`

## Requirements
- R1: A `start` pulse while `busy` is low begins a search. `busy` stays high until the result is ready. `done` is high for exactly one cycle at the end. A `start` while `busy` is high is ignored, and the result belongs to the first request.
- R2: A request f matches band b when edge[b] < f ≤ edge[b+1], with edges 46000, 62000, 93000, 125000, 187000, 250000, 375000, 500000, 750000, 1000000 and 1500000 kHz. `vcoHi` is 1 for even b. `outDivSel` is 7 − b/2 for b < 8, and 0 for b = 8 and b = 9.
- R3: If the current request matches no band, whether at the start or after a 10 kHz raise, the search ends with `errRange` = 1 and `errLimit` = 0.
- R4: The block sets q = 16 >> (7 − outDivSel) when outDivSel ≥ 4, and q = 1 otherwise. It forms t = f·q·52083, integer part I = t / 10^9 and tenths digit d = (t mod 10^9) / 10^8. For even I, the rule picks (n, m) as follows: (2, 2(I+1)) if 6d ≥ 50, (3, 3I+2) if 6d ≥ 30, and (1, I) otherwise. For odd I, it picks (1, I+1) if 6d ≥ 30, (3, 3I+1) if 6d ≥ 10, and (2, 2I) otherwise.
- R5: When n = 1, `fbkNSel` = 0 and `preBypass` = 1. Otherwise `fbkNSel` = n and `preBypass` = 0.
- R6: The feedback fields depend on m, with k = m/2:
  - m = 2 gives `fbkDivB` = 1 and all other fields 0.
  - 4 ≤ m ≤ 8 gives `preCount` = m/2 and `fbkDivA` = 1.
  - 10 ≤ m ≤ 300 gives `preCount` = k/2 − 1 with `fbkSplit` = 2 when k is even, and `preCount` = k/2 with `fbkSplit` = 1 when k is odd.
  - Any other m gives `fbkDivB` = 1 alone.
- R7: The achieved rate is 10^9·m / (52083·n·q). A successful search ends on the first request value, raised from the original in 10 kHz steps, whose achieved rate is at least that value. `achKhz` reports that achieved rate.
- R8: The block makes at most MAX_ITER evaluations (default 4096). If the last one allowed still falls short, the search ends with `errLimit` = 1. An evaluation that succeeds on the last allowed attempt is a success and raises no error.
- R9: From ui = 10^6 / achieved (taken as 1 when it is 0), the block sets `lpxCnt` = RND(50, 8ui) and `hsPrepCnt` = RND(133, 16ui) − 1, held at 0 if that would go negative. RND(x, y) is x/y plus 1 when (x mod y)·10/y ≥ 5.
- R10: `turnGoCnt` is 3 and `turnGetCnt` is 4. `wakeCnt` is RND(10^6, 52083/1000 − 1), limited to 255, which evaluates to 255.
- R11: After reset, `busy`, `done`, `errRange`, `errLimit`, `achKhz`, `lpxCnt` and `hsPrepCnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search, accepted only while idle |
| reqKhz | input | FREQ_W | Requested lane rate in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| errRange | output | 1 | Request left the supported bands |
| errLimit | output | 1 | Iteration cap reached without success |
| achKhz | output | FREQ_W+1 | Achieved rate in kHz |
| vcoHi | output | 1 | VCO range select |
| outDivSel | output | 3 | Output divider select |
| fbkNSel | output | 2 | Feedback divider n (0 when n is 1) |
| preBypass | output | 1 | Set when n is 1 |
| preCount | output | 7 | Predivider count |
| fbkSplit | output | 2 | Feedback split field |
| fbkDivA | output | 1 | Short feedback path flag |
| fbkDivB | output | 1 | Fallback feedback path flag |
| lpxCnt | output | 8 | Clock-lane LPX count |
| hsPrepCnt | output | 8 | Clock-lane HS-prepare count |
| turnGoCnt | output | 4 | Data-lane turnaround-go count |
| turnGetCnt | output | 4 | Data-lane turnaround-get count |
| wakeCnt | output | 8 | Wakeup count |

## Verification
The cap test and the rate test can fall on the same evaluation. When they do, the block must report a clean success rather than `errLimit`. To provoke this, a second instance with MAX_ITER = 1 receives the same requests as the default one. Every request whose first evaluation already covers the request must finish on that instance with no error. Every request that needs a second step must finish with `errLimit`. A second collision is a new `start` that arrives while a search is running. The bench judges it by comparing the finished result with the reference computed for the first request.

// File: rtl/dphy_pll_pkg.sv
package dphy_pll_pkg;

  localparam int NUM_BANDS = 10;

  // band edges in kHz; band b covers (edge[b], edge[b+1]]
  localparam int BAND_EDGE [NUM_BANDS+1] = '{
    46000, 62000, 93000, 125000, 187000, 250000,
    375000, 500000, 750000, 1000000, 1500000
  };

  typedef struct packed {
    logic load;
    logic doBand;
    logic doRatio;
    logic doRate;
    logic bump;
    logic doTime;
  } pllStrobe_t;

  typedef struct packed {
    logic       vcoHi;
    logic [2:0] outDivSel;
    logic [1:0] fbkNSel;
    logic       preBypass;
    logic [6:0] preCount;
    logic [1:0] fbkSplit;
    logic       fbkDivA;
    logic       fbkDivB;
  } pllFields_t;

  // integer quotient rounded up when the tenths digit is 5 or more
  function automatic logic [31:0] roundDiv(input logic [31:0] num, input logic [31:0] den);
    logic [31:0] quo;
    logic [31:0] rem;
    quo = num / den;
    rem = num % den;
    return quo + (((rem * 32'd10) / den >= 32'd5) ? 32'd1 : 32'd0);
  endfunction

endpackage

// File: rtl/dphy_pll_ctl.sv
module dphy_pll_ctl
  import dphy_pll_pkg::*;
#(
  parameter int MAX_ITER = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       anyHit,
  input  logic       rateOk,
  output pllStrobe_t stb,
  output logic       busy,
  output logic       done,
  output logic       errRange,
  output logic       errLimit
);

  localparam int IT_W = $clog2(MAX_ITER + 1);

  typedef enum logic [2:0] {S_IDLE, S_BAND, S_RATIO, S_RATE, S_TIME, S_FIN} state_t;

  state_t state, stateNext;
  logic [IT_W-1:0] itCnt;
  logic atCap;

  assign atCap = (itCnt == IT_W'(MAX_ITER - 1));

  always_comb begin
    stb         = '0;
    stb.load    = (state == S_IDLE) && start;
    stb.doBand  = (state == S_BAND) && anyHit;
    stb.doRatio = (state == S_RATIO);
    stb.doRate  = (state == S_RATE);
    stb.bump    = (state == S_RATE) && !rateOk && !atCap;
    stb.doTime  = (state == S_TIME);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (start) stateNext = S_BAND;
      S_BAND:  stateNext = anyHit ? S_RATIO : S_FIN;
      S_RATIO: stateNext = S_RATE;
      S_RATE:  begin
        // success is tested before the cap
        if (rateOk)     stateNext = S_TIME;
        else if (atCap) stateNext = S_FIN;
        else            stateNext = S_BAND;
      end
      S_TIME:  stateNext = S_FIN;
      S_FIN:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      itCnt    <= '0;
      errRange <= 1'b0;
      errLimit <= 1'b0;
    end else begin
      state <= stateNext;
      if (stb.load) begin
        itCnt    <= '0;
        errRange <= 1'b0;
        errLimit <= 1'b0;
      end else begin
        if (stb.bump) itCnt <= itCnt + 1'b1;
        if (state == S_BAND && !anyHit) errRange <= 1'b1;
        if (state == S_RATE && !rateOk && atCap) errLimit <= 1'b1;
      end
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  // R1: completion is a single-cycle pulse
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R1: a completion is always preceded by a busy cycle
  p_done_after_busy_r1: assert property (@(posedge clk) disable iff (!rstN) $rose(done) |-> $past(busy));
  // R3: the two error causes never appear together
  p_err_excl_r3: assert property (@(posedge clk) disable iff (!rstN) !(errRange && errLimit));
  // R8: the attempt counter stays below the cap
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN) 32'(itCnt) < MAX_ITER);

endmodule

// File: rtl/dphy_pll_dp.sv
module dphy_pll_dp
  import dphy_pll_pkg::*;
#(
  parameter int FREQ_W   = 21,
  parameter int CFG_KHZ  = 19200,
  parameter int STEP_KHZ = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  pllStrobe_t        stb,
  input  logic [FREQ_W-1:0] reqKhz,
  output logic              anyHit,
  output logic              rateOk,
  output pllFields_t        fields,
  output logic [FREQ_W:0]   achKhz,
  output logic [7:0]        lpxCnt,
  output logic [7:0]        hsPrepCnt
);

  localparam int ACH_W = FREQ_W + 1;
  localparam logic [39:0] PERIOD = 40'(64'd1000000000 / CFG_KHZ);
  localparam logic [39:0] GIGA   = 40'd1000000000;
  localparam logic [39:0] TENTH  = 40'd100000000;

  logic [FREQ_W-1:0] curReq;
  logic [4:0]        qReg;
  logic [1:0]        nReg;
  logic [8:0]        mReg;
  logic [ACH_W-1:0]  achReg;
  pllFields_t        fieldReg;

  // band lookup
  logic [NUM_BANDS-1:0] hit;
  logic       bandVco;
  logic [2:0] bandSel;
  logic [4:0] bandQ;

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    assign hit[b] = (curReq > FREQ_W'(BAND_EDGE[b])) && (curReq <= FREQ_W'(BAND_EDGE[b+1]));
  end

  always_comb begin
    bandVco = 1'b0;
    bandSel = 3'd0;
    for (int b = 0; b < NUM_BANDS; b++) begin
      if (hit[b]) begin
        bandVco = (b % 2 == 0);
        bandSel = (b < 8) ? 3'(7 - b / 2) : 3'd0;
      end
    end
    bandQ = (bandSel >= 3'd4) ? 5'(5'd16 >> (3'd7 - bandSel)) : 5'd1;
  end

  assign anyHit = |hit;

  // feedback ratio
  logic [39:0] tProd;
  logic [7:0]  intPart;
  logic [3:0]  tenth;
  logic [6:0]  d6;
  logic [1:0]  nNext;
  logic [8:0]  mNext;
  logic [7:0]  kHalf;
  pllFields_t  ratioFields;

  always_comb begin
    tProd   = 40'(curReq) * 40'(qReg) * PERIOD;
    intPart = 8'(tProd / GIGA);
    tenth   = 4'((tProd % GIGA) / TENTH);
    d6      = 7'(tenth) * 7'd6;
    if (!intPart[0]) begin
      if (d6 >= 7'd50)      begin nNext = 2'd2; mNext = 9'((intPart + 1) * 2); end
      else if (d6 >= 7'd30) begin nNext = 2'd3; mNext = 9'(intPart * 3 + 2);   end
      else                  begin nNext = 2'd1; mNext = 9'(intPart);           end
    end else begin
      if (d6 >= 7'd30)      begin nNext = 2'd1; mNext = 9'(intPart + 1);       end
      else if (d6 >= 7'd10) begin nNext = 2'd3; mNext = 9'(intPart * 3 + 1);   end
      else                  begin nNext = 2'd2; mNext = 9'(intPart * 2);       end
    end

    kHalf       = 8'(mNext >> 1);
    ratioFields = fieldReg;
    ratioFields.fbkNSel   = (nNext == 2'd1) ? 2'd0 : nNext;
    ratioFields.preBypass = (nNext == 2'd1);
    ratioFields.preCount  = '0;
    ratioFields.fbkSplit  = '0;
    ratioFields.fbkDivA   = 1'b0;
    ratioFields.fbkDivB   = 1'b0;
    if (mNext == 9'd2) begin
      ratioFields.fbkDivB = 1'b1;
    end else if (mNext >= 9'd4 && mNext <= 9'd8) begin
      ratioFields.preCount = 7'(kHalf);
      ratioFields.fbkDivA  = 1'b1;
    end else if (mNext >= 9'd10 && mNext <= 9'd300) begin
      if (!kHalf[0]) begin
        ratioFields.preCount = 7'((kHalf >> 1) - 8'd1);
        ratioFields.fbkSplit = 2'd2;
      end else begin
        ratioFields.preCount = 7'(kHalf >> 1);
        ratioFields.fbkSplit = 2'd1;
      end
    end else begin
      ratioFields.fbkDivB = 1'b1;
    end
  end

  // achieved rate
  logic [39:0] rateNum, rateDen, rate;
  always_comb begin
    rateNum = 40'(mReg) * GIGA;
    rateDen = PERIOD * 40'(nReg) * 40'(qReg);
    rate    = (rateDen == '0) ? '0 : rateNum / rateDen;
  end
  assign rateOk = (rate >= 40'(curReq));

  // timing counts from the achieved rate
  logic [31:0] uiRaw, uiUse, lpxFull, prepFull;
  always_comb begin
    uiRaw    = (achReg == '0) ? 32'd0 : 32'd1000000 / 32'(achReg);
    uiUse    = (uiRaw == 32'd0) ? 32'd1 : uiRaw;
    lpxFull  = roundDiv(32'd50, uiUse << 3);
    prepFull = roundDiv(32'd133, uiUse << 4);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curReq    <= '0;
      qReg      <= '0;
      nReg      <= '0;
      mReg      <= '0;
      achReg    <= '0;
      fieldReg  <= '0;
      lpxCnt    <= '0;
      hsPrepCnt <= '0;
    end else begin
      if (stb.load) curReq <= reqKhz;
      else if (stb.bump) curReq <= curReq + FREQ_W'(STEP_KHZ);
      if (stb.doBand) begin
        qReg               <= bandQ;
        fieldReg.vcoHi     <= bandVco;
        fieldReg.outDivSel <= bandSel;
      end
      if (stb.doRatio) begin
        nReg     <= nNext;
        mReg     <= mNext;
        fieldReg <= ratioFields;
      end
      if (stb.doRate) achReg <= ACH_W'(rate);
      if (stb.doTime) begin
        lpxCnt    <= (lpxFull > 32'd255) ? 8'hFF : lpxFull[7:0];
        hsPrepCnt <= (prepFull == 32'd0) ? 8'd0 :
                     ((prepFull > 32'd256) ? 8'hFF : 8'(prepFull - 32'd1));
      end
    end
  end

  assign fields = fieldReg;
  assign achKhz = achReg;

  // R7: once timing is derived the achieved rate covers the current request
  p_ach_covers_r7: assert property (@(posedge clk) disable iff (!rstN) stb.doTime |-> achReg >= ACH_W'(curReq));
  // R7: a retry raises the request by exactly one step
  p_bump_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.bump |=> curReq == $past(curReq) + FREQ_W'(STEP_KHZ));
  // R5: the bypass flag and a nonzero feedback select never coexist
  p_bypass_r5: assert property (@(posedge clk) disable iff (!rstN) fields.preBypass |-> fields.fbkNSel == 2'd0);
  // R2: output divider select is one of the legal codes
  p_sel_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    fields.outDivSel == 3'd0 || fields.outDivSel >= 3'd4);

endmodule

// File: rtl/dphy_pll_search.sv
module dphy_pll_search
  import dphy_pll_pkg::*;
#(
  parameter int FREQ_W   = 21,
  parameter int CFG_KHZ  = 19200,
  parameter int STEP_KHZ = 10,
  parameter int MAX_ITER = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FREQ_W-1:0] reqKhz,
  output logic              busy,
  output logic              done,
  output logic              errRange,
  output logic              errLimit,
  output logic [FREQ_W:0]   achKhz,
  output logic              vcoHi,
  output logic [2:0]        outDivSel,
  output logic [1:0]        fbkNSel,
  output logic              preBypass,
  output logic [6:0]        preCount,
  output logic [1:0]        fbkSplit,
  output logic              fbkDivA,
  output logic              fbkDivB,
  output logic [7:0]        lpxCnt,
  output logic [7:0]        hsPrepCnt,
  output logic [3:0]        turnGoCnt,
  output logic [3:0]        turnGetCnt,
  output logic [7:0]        wakeCnt
);

  localparam int PERIOD_PS = 1000000000 / CFG_KHZ;
  localparam int WAKE_DEN  = PERIOD_PS / 1000 - 1;
  localparam int WAKE_RAW  = 1000000 / WAKE_DEN +
                             ((((1000000 % WAKE_DEN) * 10) / WAKE_DEN >= 5) ? 1 : 0);
  localparam int WAKE_SAT  = (WAKE_RAW > 255) ? 255 : WAKE_RAW;

  pllStrobe_t stb;
  logic       anyHit, rateOk;
  pllFields_t fields;

  dphy_pll_ctl #(.MAX_ITER(MAX_ITER)) uCtl (
    .clk(clk), .rstN(rstN), .start(start), .anyHit(anyHit), .rateOk(rateOk),
    .stb(stb), .busy(busy), .done(done), .errRange(errRange), .errLimit(errLimit)
  );

  dphy_pll_dp #(.FREQ_W(FREQ_W), .CFG_KHZ(CFG_KHZ), .STEP_KHZ(STEP_KHZ)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqKhz(reqKhz), .anyHit(anyHit), .rateOk(rateOk),
    .fields(fields), .achKhz(achKhz), .lpxCnt(lpxCnt), .hsPrepCnt(hsPrepCnt)
  );

  assign vcoHi      = fields.vcoHi;
  assign outDivSel  = fields.outDivSel;
  assign fbkNSel    = fields.fbkNSel;
  assign preBypass  = fields.preBypass;
  assign preCount   = fields.preCount;
  assign fbkSplit   = fields.fbkSplit;
  assign fbkDivA    = fields.fbkDivA;
  assign fbkDivB    = fields.fbkDivB;
  assign turnGoCnt  = 4'd3;
  assign turnGetCnt = 4'd4;
  assign wakeCnt    = 8'(WAKE_SAT);

endmodule

// File: tb/sim_dphy_pll_search.sv
module sim_dphy_pll_search;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [20:0] reqKhz = '0;

  logic busy, done, errRange, errLimit, vcoHi, preBypass, fbkDivA, fbkDivB;
  logic [21:0] achKhz;
  logic [2:0] outDivSel;
  logic [1:0] fbkNSel, fbkSplit;
  logic [6:0] preCount;
  logic [7:0] lpxCnt, hsPrepCnt, wakeCnt;
  logic [3:0] turnGoCnt, turnGetCnt;

  logic busy1, done1, errRange1, errLimit1, vcoHi1, preBypass1, fbkDivA1, fbkDivB1;
  logic [21:0] achKhz1;
  logic [2:0] outDivSel1;
  logic [1:0] fbkNSel1, fbkSplit1;
  logic [6:0] preCount1;
  logic [7:0] lpxCnt1, hsPrepCnt1, wakeCnt1;
  logic [3:0] turnGoCnt1, turnGetCnt1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dphy_pll_search u0 (
    .clk(clk), .rstN(rstN), .start(start), .reqKhz(reqKhz), .busy(busy), .done(done),
    .errRange(errRange), .errLimit(errLimit), .achKhz(achKhz), .vcoHi(vcoHi),
    .outDivSel(outDivSel), .fbkNSel(fbkNSel), .preBypass(preBypass), .preCount(preCount),
    .fbkSplit(fbkSplit), .fbkDivA(fbkDivA), .fbkDivB(fbkDivB), .lpxCnt(lpxCnt),
    .hsPrepCnt(hsPrepCnt), .turnGoCnt(turnGoCnt), .turnGetCnt(turnGetCnt), .wakeCnt(wakeCnt)
  );

  dphy_pll_search #(.MAX_ITER(1)) u1 (
    .clk(clk), .rstN(rstN), .start(start), .reqKhz(reqKhz), .busy(busy1), .done(done1),
    .errRange(errRange1), .errLimit(errLimit1), .achKhz(achKhz1), .vcoHi(vcoHi1),
    .outDivSel(outDivSel1), .fbkNSel(fbkNSel1), .preBypass(preBypass1), .preCount(preCount1),
    .fbkSplit(fbkSplit1), .fbkDivA(fbkDivA1), .fbkDivB(fbkDivB1), .lpxCnt(lpxCnt1),
    .hsPrepCnt(hsPrepCnt1), .turnGoCnt(turnGoCnt1), .turnGetCnt(turnGetCnt1), .wakeCnt(wakeCnt1)
  );

  typedef struct {
    bit     rangeErr;
    bit     limitErr;
    longint ach;
    longint vco, sel, nSel, byp, preP, split, divA, divB, lpx, hsPrep;
  } expT;

  localparam longint EDGE [11] = '{46000, 62000, 93000, 125000, 187000, 250000,
                                   375000, 500000, 750000, 1000000, 1500000};

  function automatic longint rnd(longint x, longint y);
    return x / y + ((((x % y) * 10) / y >= 5) ? 1 : 0);
  endfunction

  function automatic expT refModel(longint req, int maxIt);
    expT e;
    longint f, t, q, n, m, k, ui, pr, ach;
    int idx, intP, d, tries;
    bit fin;
    e = '{default: 0};
    f = req; tries = 0; fin = 0; n = 1; m = 0; ach = 0;
    while (!fin) begin
      idx = -1;
      for (int b = 0; b < 10; b++) if (f > EDGE[b] && f <= EDGE[b+1]) idx = b;
      if (idx < 0) begin e.rangeErr = 1; return e; end
      e.vco = (idx % 2 == 0) ? 1 : 0;
      e.sel = (idx < 8) ? 7 - idx / 2 : 0;
      q = (e.sel >= 4) ? (16 >> (7 - e.sel)) : 1;
      t = f * q * 52083;
      intP = int'(t / 1000000000);
      d = int'((t % 1000000000) / 100000000);
      if (intP % 2 == 0) begin
        if (6 * d >= 50)      begin n = 2; m = (intP + 1) * 2; end
        else if (6 * d >= 30) begin n = 3; m = intP * 3 + 2; end
        else                  begin n = 1; m = intP; end
      end else begin
        if (6 * d >= 30)      begin n = 1; m = intP + 1; end
        else if (6 * d >= 10) begin n = 3; m = intP * 3 + 1; end
        else                  begin n = 2; m = intP * 2; end
      end
      ach = 64'd1000000000 * m / (52083 * n * q);
      tries++;
      if (ach >= f) fin = 1;
      else if (tries == maxIt) begin e.limitErr = 1; return e; end
      else f += 10;
    end
    e.ach  = ach;
    e.nSel = (n == 1) ? 0 : n;
    e.byp  = (n == 1) ? 1 : 0;
    k = m / 2;
    if (m == 2) e.divB = 1;
    else if (m >= 4 && m <= 8) begin e.preP = m / 2; e.divA = 1; end
    else if (m >= 10 && m <= 300) begin
      if (k % 2 == 0) begin e.preP = k / 2 - 1; e.split = 2; end
      else begin e.preP = k / 2; e.split = 1; end
    end else e.divB = 1;
    ui = 1000000 / ach;
    if (ui == 0) ui = 1;
    e.lpx = rnd(50, 8 * ui);
    pr = rnd(133, 16 * ui);
    e.hsPrep = (pr == 0) ? 0 : pr - 1;
    return e;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitDone();
    int c;
    c = 0;
    while (!done && c < 30000) begin @(negedge clk); c++; end
    chk("R1 done seen", done, 1);
  endtask

  task automatic compare(longint req);
    expT e0, e1;
    e0 = refModel(req, 4096);
    e1 = refModel(req, 1);
    chk($sformatf("R1 busy at done req=%0d", req), busy, 1);
    chk($sformatf("R3 errRange req=%0d", req), errRange, e0.rangeErr);
    chk($sformatf("R8 errLimit req=%0d", req), errLimit, e0.limitErr);
    chk($sformatf("R8 cap1 errLimit req=%0d", req), errLimit1, e1.limitErr);
    chk($sformatf("R3 cap1 errRange req=%0d", req), errRange1, e1.rangeErr);
    if (!e0.rangeErr && !e0.limitErr) begin
      chk($sformatf("R7 achKhz req=%0d", req), achKhz, e0.ach);
      chk($sformatf("R2 vcoHi req=%0d", req), vcoHi, e0.vco);
      chk($sformatf("R2 outDivSel req=%0d", req), outDivSel, e0.sel);
      chk($sformatf("R4 fbkNSel req=%0d", req), fbkNSel, e0.nSel);
      chk($sformatf("R5 preBypass req=%0d", req), preBypass, e0.byp);
      chk($sformatf("R6 preCount req=%0d", req), preCount, e0.preP);
      chk($sformatf("R6 fbkSplit req=%0d", req), fbkSplit, e0.split);
      chk($sformatf("R6 fbkDivA req=%0d", req), fbkDivA, e0.divA);
      chk($sformatf("R6 fbkDivB req=%0d", req), fbkDivB, e0.divB);
      chk($sformatf("R9 lpxCnt req=%0d", req), lpxCnt, e0.lpx);
      chk($sformatf("R9 hsPrepCnt req=%0d", req), hsPrepCnt, e0.hsPrep);
      chk("R10 turnGoCnt", turnGoCnt, 3);
      chk("R10 turnGetCnt", turnGetCnt, 4);
      chk("R10 wakeCnt", wakeCnt, 255);
    end
  endtask

  task automatic runCase(longint req);
    @(negedge clk);
    reqKhz = 21'(req);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    compare(req);
    @(negedge clk);
    chk("R1 done one cycle", done, 0);
  endtask

  initial begin
    while (cycles < 190000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<190000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint r;
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 errRange", errRange, 0);
    chk("R11 errLimit", errLimit, 0);
    chk("R11 achKhz", achKhz, 0);
    chk("R11 lpxCnt", lpxCnt, 0);
    chk("R11 hsPrepCnt", hsPrepCnt, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", busy, 0);

    // directed corners: band edges, range limits, unit interval clamp
    runCase(445500);
    runCase(320000);
    runCase(46000);     // R3 lower edge excluded
    runCase(46001);
    runCase(62000);     // R2 upper edge inclusive
    runCase(62001);
    runCase(1000000);
    runCase(1000001);   // R9 ui clamp
    runCase(1500000);   // R3 raised past top band
    runCase(1500001);
    runCase(640000);
    runCase(187000);

    // R1 start while busy is ignored
    @(negedge clk);
    reqKhz = 21'd250000; start = 1'b1;
    @(negedge clk);
    reqKhz = 21'd800000;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    compare(250000);

    // constrained random requests
    for (int i = 0; i < 14; i++) begin
      r = 46001 + longint'($urandom % 1454000);
      runCase(r);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule